// File: doc/BRIEF.md
# I2C Master Status Word and Interrupt Request

This block turns the raw event and level signals of an I2C master engine into a 16-bit read-only status word and one interrupt line. Its inputs are a start/stop detector on the bus, the engine's transaction events (address NACK, data NACK, lost arbitration, finished transfer), the write and full signals of the receive FIFO, and the fill level of a small transmit FIFO. Every flag is registered, so the status word reflects the inputs from the clock edge before.

There are two kinds of flag. Bus busy and transfer complete hold their value until a matching event clears them. The transfer complete flag is cleared by a processor-side clear strobe, and a new completion event in the same cycle wins over the strobe. All other flags follow their condition cycle by cycle. The interrupt is the OR of the enabled sources, taken from the registered flags and registered once more. It therefore rises one cycle after the flag that caused it.

Top module: `i2c_mst_status`

## Requirements
- R1: Bit 10 (bus busy) becomes 1 the cycle after `busStart` and 0 the cycle after `busStop`; when both come in one cycle, start wins; otherwise it holds.
- R2: Bit 9 (receive overflow) is 1 in the cycle after `rxWrite` and `rxFull` are both high, else 0.
- R3: Bit 8 (transfer complete) becomes 1 the cycle after `xferDone` and holds until a cycle with `clrDone` high and `xferDone` low, after which it is 0.
- R4: Bit 7 (data NACK) is 1 in the cycle after `dataNackEv` is high, else 0.
- R5: Bit 6 (master busy) is 1 in the cycle after `engineActive` is high while `arbLostEv` is low, else 0.
- R6: Bit 5 (arbitration lost) is 1 in the cycle after `arbLostEv` is high, else 0.
- R7: Bit 4 (address NACK) is 1 in the cycle after `addrNackEv` is high, else 0.
- R8: Bit 3 (receive request) is 1 in the cycle after `rxWrite` is high while `rxFull` is low, else 0.
- R9: Bit 2 (transmit request) is 1 in the cycle after `addrWrSent` is high while `txLevel` is 0 or 1, else 0.
- R10: Bits [1:0] are the previous cycle's transmit FIFO level code (00 when `txLevel` is 0, 11 when it is at least TX_DEPTH, 01 otherwise), and bits [15:11] always read 0.
- R11: `irq` is the registered OR of the flags in the status word against `irqEnable`: bit 0 enables bit 2, bit 1 enables bit 3, bit 2 enables bits 4 and 7, bit 3 enables bit 5, bit 4 enables bit 8. The enable value is sampled at the same edge as `irq`.
- R12: While `rst` is high at a clock edge, the status word becomes 0x0000 and `irq` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busStart | input | 1 | Start condition seen on the bus |
| busStop | input | 1 | Stop condition seen on the bus |
| engineActive | input | 1 | Master engine is handling a transaction |
| xferDone | input | 1 | Transfer with the addressed slave finished |
| dataNackEv | input | 1 | NACK received after a written data byte |
| addrNackEv | input | 1 | NACK received after the address |
| arbLostEv | input | 1 | Master lost arbitration for the bus |
| addrWrSent | input | 1 | An address with the write direction has been sent |
| rxWrite | input | 1 | Byte written toward the receive FIFO |
| rxFull | input | 1 | Receive FIFO is full |
| txLevel | input | $clog2(TX_DEPTH+1) | Bytes held in the transmit FIFO |
| clrDone | input | 1 | Software clear of the transfer complete flag |
| irqEnable | input | 5 | Per-source interrupt enables (see R11) |
| statusWord | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
A wrong sticky state would show up as a bus busy or transfer complete bit that stays set, or stays clear, in the status word. The first read after the event that should have changed it exposes the fault, and it stays visible until the next start, stop or clear. A wrong level flag is only visible for one cycle, so the bench compares every field on every cycle after each edge. A wrong enable mapping shows as an `irq` that is missing or extra in the cycle after the flag. The bench runs a seeded random phase and then directed cases: start and stop together, clear together with completion, and the transmit FIFO level at empty, one byte and full.

// File: rtl/i2c_mst_stat_pkg.sv
package i2c_mst_stat_pkg;

  // Bit positions of the interrupt enable vector
  localparam int EN_TX    = 0;
  localparam int EN_RX    = 1;
  localparam int EN_NACK  = 2;
  localparam int EN_ARB   = 3;
  localparam int EN_DONE  = 4;
  localparam int IRQ_SRCS = 5;

  localparam int STATUS_W = 16;

  // Strobes from the control module to the flag registers
  typedef struct packed {
    logic       setBusy;
    logic       clrBusy;
    logic       setDone;
    logic       clrDone;
    logic       rxOvf;
    logic       dataNack;
    logic       masterBusy;
    logic       arbLost;
    logic       addrNack;
    logic       rxReq;
    logic       txReq;
    logic [1:0] txCode;
  } stat_strobe_t;

endpackage

// File: rtl/i2c_mst_stat_ctrl.sv
module i2c_mst_stat_ctrl
  import i2c_mst_stat_pkg::*;
#(
  parameter int TX_DEPTH = 2,
  localparam int LVL_W   = $clog2(TX_DEPTH + 1)
) (
  input  logic             busStart,
  input  logic             busStop,
  input  logic             engineActive,
  input  logic             xferDone,
  input  logic             dataNackEv,
  input  logic             addrNackEv,
  input  logic             arbLostEv,
  input  logic             addrWrSent,
  input  logic             rxWrite,
  input  logic             rxFull,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             clrDone,
  output stat_strobe_t     strb
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(TX_DEPTH);
  localparam logic [LVL_W-1:0] ONE_LVL  = LVL_W'(1);

  logic txNearEmpty;
  assign txNearEmpty = (txLevel <= ONE_LVL);

  always_comb begin
    strb            = '0;
    strb.setBusy    = busStart;
    strb.clrBusy    = busStop;
    strb.setDone    = xferDone;
    strb.clrDone    = clrDone;
    strb.rxOvf      = rxWrite & rxFull;
    strb.rxReq      = rxWrite & ~rxFull;
    strb.dataNack   = dataNackEv;
    strb.addrNack   = addrNackEv;
    strb.arbLost    = arbLostEv;
    strb.masterBusy = engineActive & ~arbLostEv;
    strb.txReq      = addrWrSent & txNearEmpty;
    if (txLevel == '0)
      strb.txCode = 2'b00;
    else if (txLevel >= FULL_LVL)
      strb.txCode = 2'b11;
    else
      strb.txCode = 2'b01;
  end

endmodule

// File: rtl/i2c_mst_stat_dp.sv
module i2c_mst_stat_dp
  import i2c_mst_stat_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  stat_strobe_t        strb,
  input  logic [IRQ_SRCS-1:0] irqEnable,
  output logic [STATUS_W-1:0] statusWord,
  output logic                irq
);

  logic busBusy, doneFlag;
  logic ovfFlag, dNackFlag, mBusyFlag, arbFlag, aNackFlag, rxReqFlag, txReqFlag;
  logic [1:0] txCodeReg;
  logic [IRQ_SRCS-1:0] srcVec;

  // Flags that hold their value until cleared
  always_ff @(posedge clk) begin
    if (rst) begin
      busBusy  <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (strb.setBusy)      busBusy <= 1'b1;
      else if (strb.clrBusy) busBusy <= 1'b0;
      if (strb.setDone)      doneFlag <= 1'b1;
      else if (strb.clrDone) doneFlag <= 1'b0;
    end
  end

  // Flags that follow their condition
  always_ff @(posedge clk) begin
    if (rst) begin
      ovfFlag   <= 1'b0;
      dNackFlag <= 1'b0;
      mBusyFlag <= 1'b0;
      arbFlag   <= 1'b0;
      aNackFlag <= 1'b0;
      rxReqFlag <= 1'b0;
      txReqFlag <= 1'b0;
      txCodeReg <= 2'b00;
    end else begin
      ovfFlag   <= strb.rxOvf;
      dNackFlag <= strb.dataNack;
      mBusyFlag <= strb.masterBusy;
      arbFlag   <= strb.arbLost;
      aNackFlag <= strb.addrNack;
      rxReqFlag <= strb.rxReq;
      txReqFlag <= strb.txReq;
      txCodeReg <= strb.txCode;
    end
  end

  always_comb begin
    srcVec          = '0;
    srcVec[EN_TX]   = txReqFlag;
    srcVec[EN_RX]   = rxReqFlag;
    srcVec[EN_NACK] = dNackFlag | aNackFlag;
    srcVec[EN_ARB]  = arbFlag;
    srcVec[EN_DONE] = doneFlag;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(srcVec & irqEnable);
  end

  assign statusWord = {5'b00000, busBusy, ovfFlag, doneFlag, dNackFlag, mBusyFlag,
                       arbFlag, aNackFlag, rxReqFlag, txReqFlag, txCodeReg};

  // R3: a completion event always leaves the flag set
  assert_done_set_R3: assert property (@(posedge clk) disable iff (rst)
    strb.setDone |=> doneFlag);
  // R3: the flag only drops through the clear strobe
  assert_done_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (doneFlag && !strb.clrDone) |=> doneFlag);
  // R11: an interrupt never rises with every enable low
  assert_irq_enabled_R11: assert property (@(posedge clk) disable iff (rst)
    (irqEnable == '0) |=> !irq);
  // R11: with no active source, no interrupt follows
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (rst)
    (srcVec == '0) |=> !irq);

endmodule

// File: rtl/i2c_mst_status.sv
module i2c_mst_status
  import i2c_mst_stat_pkg::*;
#(
  parameter int TX_DEPTH = 2,
  localparam int LVL_W   = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busStart,
  input  logic             busStop,
  input  logic             engineActive,
  input  logic             xferDone,
  input  logic             dataNackEv,
  input  logic             addrNackEv,
  input  logic             arbLostEv,
  input  logic             addrWrSent,
  input  logic             rxWrite,
  input  logic             rxFull,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             clrDone,
  input  logic [4:0]       irqEnable,
  output logic [15:0]      statusWord,
  output logic             irq
);

  stat_strobe_t strb;

  i2c_mst_stat_ctrl #(.TX_DEPTH(TX_DEPTH)) u_ctrl (
    .busStart     (busStart),
    .busStop      (busStop),
    .engineActive (engineActive),
    .xferDone     (xferDone),
    .dataNackEv   (dataNackEv),
    .addrNackEv   (addrNackEv),
    .arbLostEv    (arbLostEv),
    .addrWrSent   (addrWrSent),
    .rxWrite      (rxWrite),
    .rxFull       (rxFull),
    .txLevel      (txLevel),
    .clrDone      (clrDone),
    .strb         (strb)
  );

  i2c_mst_stat_dp u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .irqEnable  (irqEnable),
    .statusWord (statusWord),
    .irq        (irq)
  );

  // R1: a start always marks the bus busy
  assert_busy_start_R1: assert property (@(posedge clk) disable iff (rst)
    busStart |=> statusWord[10]);
  // R1: a lone stop frees the bus
  assert_busy_stop_R1: assert property (@(posedge clk) disable iff (rst)
    (busStop && !busStart) |=> !statusWord[10]);
  // R2: a write into a full receive FIFO is flagged
  assert_rx_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (rxWrite && rxFull) |=> statusWord[9]);
  // R10: an empty transmit FIFO reads as code 00
  assert_tx_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (txLevel == '0) |=> (statusWord[1:0] == 2'b00));
  // R10: reserved bits stay zero
  always_comb begin
    if (!rst) assert_reserved_R10: assert (statusWord[15:11] == 5'b0);
  end

endmodule

// File: tb/sim_i2c_mst_status.sv
module sim_i2c_mst_status;

  localparam int CLK_PERIOD = 10;
  localparam int TX_DEPTH   = 2;
  localparam int LVL_W      = $clog2(TX_DEPTH + 1);
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst;
  logic busStart, busStop, engineActive, xferDone, dataNackEv, addrNackEv;
  logic arbLostEv, addrWrSent, rxWrite, rxFull, clrDone;
  logic [LVL_W-1:0] txLevel;
  logic [4:0] irqEnable;
  logic [15:0] statusWord;
  logic irq;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  logic [15:0] expWord;
  logic        expIrq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_mst_status #(.TX_DEPTH(TX_DEPTH)) u0 (
    .clk(clk), .rst(rst), .busStart(busStart), .busStop(busStop),
    .engineActive(engineActive), .xferDone(xferDone), .dataNackEv(dataNackEv),
    .addrNackEv(addrNackEv), .arbLostEv(arbLostEv), .addrWrSent(addrWrSent),
    .rxWrite(rxWrite), .rxFull(rxFull), .txLevel(txLevel), .clrDone(clrDone),
    .irqEnable(irqEnable), .statusWord(statusWord), .irq(irq)
  );

  function automatic logic [1:0] levelCode(input logic [LVL_W-1:0] lvl);
    if (lvl == '0) return 2'b00;
    if (int'(lvl) >= TX_DEPTH) return 2'b11;
    return 2'b01;
  endfunction

  // Interrupt sources as listed in R11
  function automatic logic [4:0] sources(input logic [15:0] w);
    return {w[8], w[5], w[4] | w[7], w[3], w[2]};
  endfunction

  function automatic logic [15:0] modelWord(input logic [15:0] w);
    logic [15:0] n;
    n = '0;
    n[10] = busStart ? 1'b1 : (busStop ? 1'b0 : w[10]);
    n[9]  = rxWrite & rxFull;
    n[8]  = xferDone ? 1'b1 : (clrDone ? 1'b0 : w[8]);
    n[7]  = dataNackEv;
    n[6]  = engineActive & ~arbLostEv;
    n[5]  = arbLostEv;
    n[4]  = addrNackEv;
    n[3]  = rxWrite & ~rxFull;
    n[2]  = addrWrSent & (int'(txLevel) <= 1);
    n[1:0] = levelCode(txLevel);
    return n;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R1",  16'(statusWord[10]),    16'(expWord[10]));
    check("R2",  16'(statusWord[9]),     16'(expWord[9]));
    check("R3",  16'(statusWord[8]),     16'(expWord[8]));
    check("R4",  16'(statusWord[7]),     16'(expWord[7]));
    check("R5",  16'(statusWord[6]),     16'(expWord[6]));
    check("R6",  16'(statusWord[5]),     16'(expWord[5]));
    check("R7",  16'(statusWord[4]),     16'(expWord[4]));
    check("R8",  16'(statusWord[3]),     16'(expWord[3]));
    check("R9",  16'(statusWord[2]),     16'(expWord[2]));
    check("R10", 16'(statusWord[1:0]),   16'(expWord[1:0]));
    check("R10", 16'(statusWord[15:11]), 16'h0);
    check("R11", 16'(irq),               16'(expIrq));
  endtask

  // Inputs are driven away from the edge; the model advances at the edge
  task automatic step();
    @(posedge clk);
    if (rst) begin
      expWord = '0;
      expIrq  = 1'b0;
    end else begin
      expIrq  = |(sources(expWord) & irqEnable);
      expWord = modelWord(expWord);
    end
    #1;
    compareAll();
    @(negedge clk);
  endtask

  task automatic idleInputs();
    busStart = 0; busStop = 0; engineActive = 0; xferDone = 0;
    dataNackEv = 0; addrNackEv = 0; arbLostEv = 0; addrWrSent = 0;
    rxWrite = 0; rxFull = 0; clrDone = 0; txLevel = '0;
  endtask

  task automatic randomInputs();
    busStart     = ($urandom_range(0, 7) == 0);
    busStop      = ($urandom_range(0, 7) == 0);
    engineActive = ($urandom_range(0, 1) == 0);
    xferDone     = ($urandom_range(0, 9) == 0);
    dataNackEv   = ($urandom_range(0, 9) == 0);
    addrNackEv   = ($urandom_range(0, 9) == 0);
    arbLostEv    = ($urandom_range(0, 9) == 0);
    addrWrSent   = ($urandom_range(0, 1) == 0);
    rxWrite      = ($urandom_range(0, 2) == 0);
    rxFull       = ($urandom_range(0, 2) == 0);
    clrDone      = ($urandom_range(0, 5) == 0);
    txLevel      = LVL_W'($urandom_range(0, TX_DEPTH));
    irqEnable    = 5'($urandom_range(0, 31));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    idleInputs();
    irqEnable = '0;
    rst = 1;
    expWord = 'x;
    expIrq  = 1'bx;
    @(negedge clk);
    // R12: reset state after random-looking prior activity
    busStart = 1; xferDone = 1; rxWrite = 1;
    step();
    step();
    check("R12", statusWord, 16'h0000);
    check("R12", 16'(irq), 16'h0);
    rst = 0;
    idleInputs();

    // Seeded random phase, every field compared each cycle
    for (int i = 0; i < 600; i++) begin
      randomInputs();
      step();
    end

    // R1: start and stop in one cycle, start wins
    idleInputs(); irqEnable = '0;
    busStop = 1; step();
    busStart = 1; busStop = 1; step();
    check("R1", 16'(statusWord[10]), 16'h1);
    busStart = 0; busStop = 0; step();
    check("R1", 16'(statusWord[10]), 16'h1);

    // R3: clear together with completion keeps the flag; lone clear drops it
    irqEnable = 5'b10000;
    xferDone = 1; step();
    xferDone = 1; clrDone = 1; step();
    check("R3", 16'(statusWord[8]), 16'h1);
    xferDone = 0; clrDone = 0; step();
    check("R11", 16'(irq), 16'h1);
    clrDone = 1; step();
    check("R3", 16'(statusWord[8]), 16'h0);
    clrDone = 0; step();
    check("R11", 16'(irq), 16'h0);

    // R10 and R9: level boundaries of the transmit FIFO
    addrWrSent = 1;
    for (int l = 0; l <= TX_DEPTH; l++) begin
      txLevel = LVL_W'(l);
      step();
      check("R10", 16'(statusWord[1:0]), 16'(levelCode(LVL_W'(l))));
      check("R9",  16'(statusWord[2]), 16'((l <= 1) ? 1 : 0));
    end

    // R11: shared NACK enable covers address NACK
    idleInputs(); irqEnable = 5'b00100;
    addrNackEv = 1; step();
    addrNackEv = 0; step();
    check("R7",  16'(statusWord[4]), 16'h0);
    check("R11", 16'(irq), 16'h1);

    // R12: reset in the middle of activity
    xferDone = 1; busStart = 1; step();
    rst = 1; step();
    check("R12", statusWord, 16'h0000);
    rst = 0; idleInputs(); step();

    finish();
  end

endmodule